// File: doc/BRIEF.md
# Table-Driven Programmable State Machine

This block is a clocked sequential machine whose next-state and output logic live entirely in a writable lookup table, with no fixed gates doing that job. A register of edge-triggered flip-flops holds the encoded present state. The present-state code is joined with the primary inputs to form a table address. The word read at that address gives both the next-state code and the output bits, and the read is purely combinational. Outputs can therefore follow the inputs within the same cycle, which is Mealy form.

A host loads the table one word per clock through a simple write port. Loading a different table gives a different machine, and none of the surrounding logic changes. While the table is being loaded, a run input can be held low to freeze the state register.

The state width, input width and output width are parameters. The state width is the ceiling of log2 of the number of states. The default build has two state bits (four states), one input and one output.

Top module: `fsm_prog_top`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) forces the present-state code `state_o` to 0.
- R2: When run is high and rst is low, the state register loads the next-state field on each rising edge. That field is the one held in the word at the address formed from the present state and `in_i` just before the edge.
- R3: `out_o` equals the output field of the word at the current address, and it changes combinationally with `in_i` and with the present state.
- R4: When run is low and rst is low, `state_o` keeps its value across the edge, whatever `in_i` is.
- R5: When `wr_en` is high at an edge, the word at `wr_addr` is replaced by `wr_data`. Reads return the new word from that edge onward. A state update at that same edge uses the word as it was before the write.
- R6: Before any write, every table word is zero. An unprogrammed machine therefore stays in state 0 with all outputs low, for any input.
- R7: Reset does not alter the table contents, so after reset the machine follows the table that was loaded before it.
- R8: Loading different table contents changes the sequence of states and outputs produced for the same input stream.
- R9: The table address is {present state, inputs}, with the state in the upper bits. A word is {next state, outputs}, with the next state in the upper ST_W bits and the outputs in the lower OUT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the state register |
| run | input | 1 | High lets the state advance; low freezes it |
| in_i | input | IN_W | Primary inputs of the machine |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ST_W+IN_W | Table address to write, laid out as {state, inputs} |
| wr_data | input | ST_W+OUT_W | Word to write, laid out as {next state, outputs} |
| out_o | output | OUT_W | Output field of the currently addressed word |
| state_o | output | ST_W | Present-state code |

## Verification
The assertions assume that `rst` is asserted at least once before any check is armed. They also assume that `wr_en`, `wr_addr`, `wr_data`, `run` and `in_i` are settled at each rising edge, so the values sampled at the edge are the ones the table and the register act on. The stimulus changes every input only at the falling edge, and it holds reset high for the first two cycles. Writes are issued both with run low and, deliberately, with run high at the word currently being read. This exercises the ordering in R5 without ever leaving the inputs undefined at an edge.

// File: rtl/fsm_pkg.sv
package fsm_pkg;
  localparam int DEF_ST_W  = 2;
  localparam int DEF_IN_W  = 1;
  localparam int DEF_OUT_W = 1;

  function automatic int tbl_depth(input int st_w, input int in_w);
    return 1 << (st_w + in_w);
  endfunction
endpackage

// File: rtl/fsm_table.sv
module fsm_table #(
  parameter int AW = 3,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  assert_write_visible_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wr_en) && rd_addr == $past(wr_addr)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/fsm_addr_join.sv
module fsm_addr_join #(
  parameter int ST_W  = 2,
  parameter int IN_W  = 1,
  parameter int OUT_W = 1
) (
  input  logic [ST_W-1:0]       state_i,
  input  logic [IN_W-1:0]       in_i,
  input  logic [ST_W+OUT_W-1:0] word_i,
  output logic [ST_W+IN_W-1:0]  addr_o,
  output logic [ST_W-1:0]       next_o,
  output logic [OUT_W-1:0]      out_o
);
  assign addr_o = {state_i, in_i};
  assign next_o = word_i[ST_W+OUT_W-1 -: ST_W];
  assign out_o  = word_i[OUT_W-1:0];
endmodule

// File: rtl/fsm_state_reg.sv
module fsm_state_reg #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [ST_W-1:0] next_i,
  output logic [ST_W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (rst)      state_q <= '0;
    else if (run) state_q <= next_i;
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> state_q == '0);

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(run)) |-> state_q == $past(next_i));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(run)) |-> $stable(state_q));
endmodule

// File: rtl/fsm_prog_top.sv
module fsm_prog_top #(
  parameter int ST_W  = fsm_pkg::DEF_ST_W,
  parameter int IN_W  = fsm_pkg::DEF_IN_W,
  parameter int OUT_W = fsm_pkg::DEF_OUT_W,
  localparam int AW   = ST_W + IN_W,
  localparam int DW   = ST_W + OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [IN_W-1:0]  in_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [OUT_W-1:0] out_o,
  output logic [ST_W-1:0]  state_o
);
  logic [AW-1:0]   rd_addr;
  logic [DW-1:0]   rd_word;
  logic [ST_W-1:0] next_code;
  logic [ST_W-1:0] state_q;

  fsm_table #(.AW(AW), .DW(DW)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_word)
  );

  fsm_addr_join #(.ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_join (
    .state_i(state_q), .in_i(in_i), .word_i(rd_word),
    .addr_o(rd_addr), .next_o(next_code), .out_o(out_o)
  );

  fsm_state_reg #(.ST_W(ST_W)) u_state (
    .clk(clk), .rst(rst), .run(run), .next_i(next_code), .state_q(state_q)
  );

  assign state_o = state_q;
endmodule

// File: tb/fsm_prog_top_test.sv
module fsm_prog_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [0:0] in_i = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [2:0] wr_data = '0;
  logic [0:0] out_o;
  logic [1:0] state_o;

  fsm_prog_top uut (
    .clk(clk), .rst(rst), .run(run), .in_i(in_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_o(out_o), .state_o(state_o)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2:0] ref_mem [8];
  logic [1:0] ref_st = '0;

  logic [1:0] q_st  [$];
  logic       q_out [$];
  string      q_req [$];

  // Monitor: pop each expected item and compare against the live ports
  initial begin
    forever begin
      wait (q_st.size() > 0);
      begin
        logic [1:0] es;
        logic       eo;
        string      rq;
        es = q_st.pop_front();
        eo = q_out.pop_front();
        rq = q_req.pop_front();
        n_cmp++;
        if (state_o !== es || out_o[0] !== eo) begin
          n_bad++;
          $display("FAIL %s: state=%0d out=%0d expected state=%0d out=%0d",
                   rq, state_o, out_o, es, eo);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, pushes expected port values, advances model
  task automatic cycle(input bit r, input bit rn, input bit x,
                       input bit we, input logic [2:0] wa, input logic [2:0] wd,
                       input string req);
    @(negedge clk);
    rst = r; run = rn; in_i[0] = x; wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    q_st.push_back(ref_st);
    q_out.push_back(ref_mem[{ref_st, x}][0]);
    q_req.push_back(req);
    @(posedge clk);
    if (r)       ref_st = 2'd0;
    else if (rn) ref_st = ref_mem[{ref_st, x}][2:1];
    if (we) ref_mem[wa] = wd;
  endtask

  task automatic prog(input logic [2:0] a, input logic [2:0] d);
    cycle(1'b0, 1'b0, 1'b0, 1'b1, a, d, "R4");
  endtask

  task automatic run_bits(input logic [7:0] pat, input string req);
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, pat[i], 1'b0, 3'd0, 3'd0, req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = 3'd0;
    // R1: reset state
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, "R1");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, "R1");
    // R6: unprogrammed table keeps state 0, outputs low
    run_bits(8'b1011_0110, "R6");
    // Program table while frozen (R9 layout: addr {s,x}, word {ns,out}); R4 holds
    prog(3'b000, 3'b011); prog(3'b001, 3'b100);
    prog(3'b010, 3'b111); prog(3'b011, 3'b000);
    prog(3'b100, 3'b101); prog(3'b101, 3'b111);
    prog(3'b110, 3'b010); prog(3'b111, 3'b001);
    // R2/R3: several input patterns
    run_bits(8'b0000_0000, "R2");
    run_bits(8'b1111_1111, "R3");
    run_bits(8'b1010_0110, "R9");
    // R4: hold with varying inputs
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, i[0], 1'b0, 3'd0, 3'd0, "R4");
    // R5: write the currently addressed word while running
    cycle(1'b0, 1'b1, 1'b0, 1'b1, {ref_st, 1'b0}, 3'b110, "R5");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, "R5");
    cycle(1'b0, 1'b1, 1'b0, 1'b1, {ref_st, 1'b0}, 3'b011, "R5");
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, "R5");
    run_bits(8'b0110_1001, "R5");
    // R7: reset mid-run keeps table
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, "R7");
    run_bits(8'b1100_1010, "R7");
    // R8: reprogram to a different machine
    for (int a = 0; a < 8; a++) prog(a[2:0], {a[1:0] ^ 2'b11, a[2]});
    run_bits(8'b0011_0101, "R8");
    run_bits(8'b1110_0001, "R8");
    @(negedge clk);
    wait (q_st.size() == 0);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule